// File: doc/BRIEF.md
# Triggered Command Queue Scan Controller

This block holds a small set of command queues and streams their conversion commands, one word at a time, over a shared valid/ready output to a converter interface. Each queue is loaded through a common write port. An enable input gates the queue, and a mode bit chooses one-shot scanning or repeated scanning. A queue releases nothing until it is armed and then triggered, either by a software strobe or by a hardware trigger line.

Bit 31 of every command word marks the last command of a scan. When a one-shot queue sends that command, it parks and refuses triggers until it receives a rearm strobe. A repeating queue instead goes back to waiting for a trigger, and its next scan replays the stored list from the first entry. Commands are never consumed from storage. A scan walks a read pointer over the stored list and resets it at the end-of-queue command.

When several queues run at the same time, the lowest-numbered one owns the output. Once a command has been offered, it stays on the output until it is accepted. Result collection lies outside this block and runs independently of it.

Top module: `cmd_scan_ctrl`

## Requirements
- R1: After reset every queue reads state 0 (disabled), `q_overrun` is all zeros and `cmd_valid` is low. `q_state` carries queue i in bits [2i+1:2i], with the code 0=disabled, 1=armed, 2=running, 3=stopped.
- R2: An enabled queue moves from disabled to armed on the next clock. Dropping its enable forces it to disabled on the next clock, clears its overrun bit and restarts its read position. While it is disabled, triggers have no effect.
- R3: A software or hardware trigger on an armed queue makes it running on the next clock. Only a running queue is ever shown on `cmd_valid`/`cmd_qid`.
- R4: A running queue issues its stored commands in write order, starting from the first entry of the list on every scan. `cmd_data` equals the written word, with bit 31 as the end-of-queue flag.
- R5: In one-shot mode (`cont_mode` bit 0), an accepted command with bit 31 set moves the queue to stopped. A stopped queue stays stopped under any trigger.
- R6: A rearm strobe moves a stopped queue to armed. A later trigger then scans the same list again.
- R7: In repeating mode (`cont_mode` bit 1), an accepted end-of-queue command returns the queue to armed. The next trigger replays the list from its first entry.
- R8: When no command is being held, the running queue with the lowest index that has a command ready drives the output.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_data` and `cmd_qid` hold steady into the next cycle, even if a higher-priority queue starts running.
- R10: A trigger that arrives while a queue is running sets that queue's overrun bit. The scan continues undisturbed.
- R11: A running queue that has sent every stored command without meeting an end-of-queue flag stays running with `cmd_valid` low. It resumes as soon as a new command is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one command into the selected queue (ignored when that queue is full) |
| wr_qsel | input | QW | Queue index for the write |
| wr_data | input | CW | Command word to store |
| enable | input | NQ | Per-queue enable |
| cont_mode | input | NQ | Per-queue scan mode: 1 repeating, 0 one-shot |
| sw_trig | input | NQ | Per-queue software trigger strobe |
| hw_trig | input | NQ | Per-queue hardware trigger line |
| rearm | input | NQ | Per-queue rearm strobe |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | The converter side accepts the offered command |
| cmd_data | output | CW | Offered command word |
| cmd_qid | output | QW | Index of the queue that owns the offered command |
| q_state | output | 2*NQ | Per-queue state code |
| q_overrun | output | NQ | Per-queue overrun flag |

## Verification
A queue stuck in the wrong state becomes visible at the ports within one clock. The `q_state` field is read out directly, and the next command either appears on the output or fails to appear. A read pointer that fails to reset at the end of the queue shows up at the next trigger, because that queue offers a word other than its first stored command. Arbitration and hold faults appear in the same cycle as a wrong `cmd_qid`, or on the next clock as a changed `cmd_data` while `cmd_ready` is low.

// File: rtl/cmd_scan_ctrl.sv
module cmd_scan_ctrl #(
  parameter int NQ    = 3,
  parameter int DEPTH = 4,
  parameter int CW    = 32,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [QW-1:0]   wr_qsel,
  input  logic [CW-1:0]   wr_data,
  input  logic [NQ-1:0]   enable,
  input  logic [NQ-1:0]   cont_mode,
  input  logic [NQ-1:0]   sw_trig,
  input  logic [NQ-1:0]   hw_trig,
  input  logic [NQ-1:0]   rearm,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [CW-1:0]   cmd_data,
  output logic [QW-1:0]   cmd_qid,
  output logic [2*NQ-1:0] q_state,
  output logic [NQ-1:0]   q_overrun
);
  typedef enum logic [1:0] {S_OFF = 2'd0, S_ARM = 2'd1, S_RUN = 2'd2, S_STOP = 2'd3} qst_t;

  logic [CW-1:0] mem  [NQ][DEPTH];
  logic [PW-1:0] cnt  [NQ];
  logic [PW-1:0] rptr [NQ];
  qst_t          st   [NQ];
  logic [NQ-1:0] rdy_q;
  logic          held;
  logic [QW-1:0] held_q, pick, sel;
  logic          hs;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign rdy_q[g]           = (st[g] == S_RUN) && (rptr[g] < cnt[g]);
    assign q_state[2*g +: 2]  = st[g];
  end

  always_comb begin
    pick = '0;
    for (int i = NQ - 1; i >= 0; i--)
      if (rdy_q[i]) pick = QW'(i);
  end

  assign sel       = (held && st[held_q] == S_RUN) ? held_q : pick;
  assign cmd_valid = rdy_q[sel];
  assign cmd_qid   = sel;
  assign cmd_data  = mem[sel][rptr[sel][AW-1:0]];
  assign hs        = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NQ; i++)
      if (wr_en && wr_qsel == QW'(i) && cnt[i] < PW'(DEPTH))
        mem[i][cnt[i][AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= 1'b0;
      held_q <= '0;
      for (int i = 0; i < NQ; i++) begin
        st[i]        <= S_OFF;
        cnt[i]       <= '0;
        rptr[i]      <= '0;
        q_overrun[i] <= 1'b0;
      end
    end else begin
      if (hs) held <= 1'b0;
      else if (cmd_valid) begin
        held   <= 1'b1;
        held_q <= sel;
      end
      for (int i = 0; i < NQ; i++) begin
        if (wr_en && wr_qsel == QW'(i) && cnt[i] < PW'(DEPTH))
          cnt[i] <= cnt[i] + 1'b1;
        if (!enable[i]) begin
          st[i]        <= S_OFF;
          rptr[i]      <= '0;
          q_overrun[i] <= 1'b0;
        end else begin
          case (st[i])
            S_OFF:  st[i] <= S_ARM;
            S_ARM:  if (sw_trig[i] || hw_trig[i]) st[i] <= S_RUN;
            S_RUN: begin
              if (sw_trig[i] || hw_trig[i]) q_overrun[i] <= 1'b1;
              if (hs && sel == QW'(i)) begin
                if (cmd_data[CW-1]) begin
                  rptr[i] <= '0;
                  st[i]   <= cont_mode[i] ? S_ARM : S_STOP;
                end else begin
                  rptr[i] <= rptr[i] + 1'b1;
                end
              end
            end
            default: if (rearm[i]) st[i] <= S_ARM;
          endcase
        end
      end
    end
  end
endmodule

module cmd_scan_ctrl_props #(
  parameter int NQ = 3,
  parameter int CW = 32,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NQ-1:0]   enable,
  input logic [NQ-1:0]   cont_mode,
  input logic [NQ-1:0]   sw_trig,
  input logic [NQ-1:0]   hw_trig,
  input logic [NQ-1:0]   rearm,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [CW-1:0]   cmd_data,
  input logic [QW-1:0]   cmd_qid,
  input logic [2*NQ-1:0] q_state,
  input logic [NQ-1:0]   q_overrun
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && enable[cmd_qid]) |=>
      (cmd_valid && $stable(cmd_data) && $stable(cmd_qid)));

  assert_valid_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (q_state[2*cmd_qid +: 2] == 2'd2));

  for (genvar g = 0; g < NQ; g++) begin : g_chk
    assert_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !enable[g] |=> (q_state[2*g +: 2] == 2'd0 && !q_overrun[g]));

    assert_single_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_qid == QW'(g) && cmd_data[CW-1] &&
       enable[g] && !cont_mode[g]) |=> (q_state[2*g +: 2] == 2'd3));

    assert_stopped_ignores_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (q_state[2*g +: 2] == 2'd3 && enable[g] && !rearm[g]) |=> (q_state[2*g +: 2] == 2'd3));

    assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q_state[2*g +: 2] == 2'd2 && enable[g] && (sw_trig[g] || hw_trig[g])) |=>
        (q_overrun[g] && q_state[2*g +: 2] != 2'd0));
  end
endmodule

bind cmd_scan_ctrl cmd_scan_ctrl_props #(.NQ(NQ), .CW(CW)) u_props (.*);

// File: tb/cmd_scan_ctrl_test.sv
module cmd_scan_ctrl_test;
  localparam int NQ = 3;
  localparam int CW = 32;
  localparam int QW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [QW-1:0] wr_qsel = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NQ-1:0] enable = '0, cont_mode = '0, sw_trig = '0, hw_trig = '0, rearm = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [CW-1:0] cmd_data;
  logic [QW-1:0] cmd_qid;
  logic [2*NQ-1:0] q_state;
  logic [NQ-1:0] q_overrun;
  int tests = 0, fails = 0;
  bit done = 0;

  cmd_scan_ctrl #(.NQ(NQ), .DEPTH(4), .CW(CW)) uut (.*);

  always #5 clk = ~clk;

  // {ready, exp_valid, exp_qid[1:0], exp_data[31:0]}
  localparam logic [35:0] VEC [8] = '{
    {1'b0, 1'b1, 2'd0, 32'h0000_0011},
    {1'b1, 1'b1, 2'd0, 32'h0000_0011},
    {1'b1, 1'b1, 2'd0, 32'h0000_0012},
    {1'b1, 1'b1, 2'd0, 32'h8000_0013},
    {1'b0, 1'b1, 2'd1, 32'h0000_0021},
    {1'b1, 1'b1, 2'd1, 32'h0000_0021},
    {1'b1, 1'b1, 2'd1, 32'h8000_0022},
    {1'b1, 1'b0, 2'd0, 32'h0000_0000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int q, input logic [31:0] d);
    wr_en = 1'b1; wr_qsel = QW'(q); wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic trig_sw(input int q);
    sw_trig[q] = 1'b1;
    step();
    sw_trig = '0;
  endtask

  function automatic logic [31:0] st(input int q);
    return 32'(q_state[2*q +: 2]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", 32'(cmd_valid), 0);
    check("R1 state", 32'(q_state), 0);
    check("R1 overrun", 32'(q_overrun), 0);
    rst_n = 1'b1;
    enable = 3'b111; cont_mode = 3'b010;
    step();
    check("R2 armed", 32'(q_state), 32'b010101);
    wr(0, 32'h11); wr(0, 32'h12); wr(0, 32'h8000_0013);
    wr(1, 32'h21); wr(1, 32'h8000_0022);
    check("R3 no output while armed", 32'(cmd_valid), 0);
    sw_trig[0] = 1'b1; hw_trig[1] = 1'b1;
    step();
    sw_trig = '0; hw_trig = '0;
    check("R3 q0 running", st(0), 2);
    check("R3 q1 running", st(1), 2);

    for (int k = 0; k < 8; k++) begin
      cmd_ready = VEC[k][35];
      #1;
      check("R4/R8 valid", 32'(cmd_valid), 32'(VEC[k][34]));
      if (VEC[k][34]) begin
        check("R8 qid", 32'(cmd_qid), 32'(VEC[k][33:32]));
        check("R4 data", cmd_data, VEC[k][31:0]);
      end
      step();
    end
    check("R5 q0 stopped", st(0), 3);
    check("R7 q1 armed", st(1), 1);
    check("R2 q2 armed", st(2), 1);

    trig_sw(0);
    check("R5 stopped ignores trigger", st(0), 3);
    check("R5 no output", 32'(cmd_valid), 0);
    rearm[0] = 1'b1; step(); rearm = '0;
    check("R6 rearmed", st(0), 1);

    cmd_ready = 1'b0;
    hw_trig[1] = 1'b1; step(); hw_trig = '0;
    check("R7 rescan qid", 32'(cmd_qid), 1);
    check("R7 rescan first entry", cmd_data, 32'h21);
    trig_sw(0);
    check("R9 held qid", 32'(cmd_qid), 1);
    check("R9 held data", cmd_data, 32'h21);
    check("R9 q0 running", st(0), 2);
    cmd_ready = 1'b1;
    step();
    check("R8 q0 takes over", 32'(cmd_qid), 0);
    check("R6 rescan first entry", cmd_data, 32'h11);
    trig_sw(0);
    check("R10 overrun set", 32'(q_overrun), 3'b001);
    check("R10 scan continues", cmd_data, 32'h12);
    step();
    check("R4 third entry", cmd_data, 32'h8000_0013);
    step();
    check("R8 q1 resumes", 32'(cmd_qid), 1);
    check("R4 q1 second entry", cmd_data, 32'h8000_0022);
    step();
    check("R7 q1 armed again", st(1), 1);
    check("R5 q0 stopped again", st(0), 3);
    check("R7 idle", 32'(cmd_valid), 0);

    wr(2, 32'h31);
    trig_sw(2);
    check("R11 q2 first", cmd_data, 32'h31);
    check("R11 q2 qid", 32'(cmd_qid), 2);
    step();
    check("R11 stall valid", 32'(cmd_valid), 0);
    check("R11 stall running", st(2), 2);
    wr(2, 32'h8000_0032);
    check("R11 resumes", 32'(cmd_valid), 1);
    check("R11 new word", cmd_data, 32'h8000_0032);
    step();
    check("R5 q2 stopped", st(2), 3);

    enable[0] = 1'b0; step();
    check("R2 disabled", st(0), 0);
    check("R2 overrun cleared", 32'(q_overrun), 0);
    trig_sw(0);
    check("R2 trigger ignored", st(0), 0);
    enable[0] = 1'b1; step();
    check("R2 re-armed", st(0), 1);
    trig_sw(0);
    check("R4 restart from first", cmd_data, 32'h11);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule